// File: doc/BRIEF.md
# Serial DMA Completion Interrupt Controller

This block turns completion strobes from a DMA engine into interrupt requests for a synchronous serial port. It has a transmit channel and a receive channel. Each channel has a DMA enable bit, a latched raw completion bit, an interrupt mask bit and a write-one-to-clear bit. A small register port lets software set the enables and masks, read the raw and masked status, and clear latched completions. One registered interrupt line carries the OR of the masked status bits.

The two channels differ in one way. A receive completion is one-shot: it latches on a done strobe and stays set until software clears it. A transmit completion stays asserted while transmit DMA remains enabled. Software must therefore clear the transmit enable first and then write the clear bit. Setting the transmit enable again lets later transfers raise the interrupt again.

Top module: `sdi_dma_irq`

## Requirements
- R1: After synchronous reset, every readable register reads 0 and `irq` is 0.
- R2: Address 0 holds the DMA enables (bit 0 transmit, bit 1 receive) and address 1 holds the interrupt masks (same bit order). Both are written with `wr_en` and read back unchanged on `rdata`.
- R3: A receive done strobe while the receive enable is set makes raw status bit 1 (address 2) read 1 from the next cycle. The bit then stays 1 until it is cleared.
- R4: A done strobe for a channel whose DMA enable is 0 leaves that channel's raw status bit unchanged.
- R5: Writing to address 4 clears every raw status bit whose data bit is 1, from the next cycle. Data bits that are 0 have no effect. Address 4 reads as 0.
- R6: Once a transmit completion has been recorded, a clear of bit 0 has no effect while the transmit enable stays 1.
- R7: Once the transmit enable has been written to 0, a later clear of bit 0 takes effect. After the enable is set to 1 again, raw bit 0 stays 0 until a new transmit done strobe arrives.
- R8: Address 3 reads the masked status, which is raw status AND mask. Raw status at address 2 is readable whatever the mask holds.
- R9: `irq` equals the OR of the masked status bits with one cycle of register delay.
- R10: When a clear and a new completion event for the same channel fall in the same cycle, the status bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 2 | Write data, one bit per channel |
| rdata | output | 2 | Read data for `addr`, combinational |
| tx_done | input | 1 | Transmit DMA completion strobe |
| rx_done | input | 1 | Receive DMA completion strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong bit in a latched status shows on the raw read at address 2 in the cycle after the event. It shows on `irq` one cycle after that, unless the mask hides it; the masked read at address 3 separates mask faults from status faults. A lost transmit completion record shows only after a clear that should have been blocked, so the stimulus mixes clears with enable toggles and fires done strobes in the same cycle as clears. A reference model in the bench compares every read and every `irq` value on every cycle, so a divergence shows within one cycle.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 3;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_MASK  = 3'd1,
        A_RAW   = 3'd2,
        A_MSTAT = 3'd3,
        A_CLR   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NCH-1:0] dma_en;
        logic [NCH-1:0] mask;
    } cfg_t;

    // Transmit completion is sustained while its DMA enable stays set.
    function automatic bit ch_sustains(int ch);
        return ch == CH_TX;
    endfunction
endpackage

// File: rtl/sdi_cfg_regs.sv
module sdi_cfg_regs
    import sdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCH-1:0]    wdata,
    output cfg_t              cfg,
    output logic [NCH-1:0]    clr_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CTRL:  cfg.dma_en <= wdata;
                A_MASK:  cfg.mask   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_pulse = '0;
        if (wr_en && reg_addr_e'(addr) == A_CLR) clr_pulse = wdata;
    end

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/sdi_done_chan.sv
module sdi_done_chan #(
    parameter bit SUSTAIN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic done,
    input  logic clr,
    output logic status
);
    logic hold;

    generate
        if (SUSTAIN) begin : g_sustain
            logic fin;
            always_ff @(posedge clk) begin
                if (rst)      fin <= 1'b0;
                else if (!en) fin <= 1'b0;
                else if (done) fin <= 1'b1;
            end
            assign hold = fin & en;

            p_clear_blocked_r6: assert property (@(posedge clk) disable iff (rst)
                (fin && en && clr) |=> status);
        end else begin : g_oneshot
            assign hold = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) status <= 1'b0;
        else     status <= (done & en) | hold | (status & ~clr);
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status);
    p_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!status && !en) |=> !status);
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (status && clr && !(done && en) && !hold) |=> !status);
    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (done && en && clr) |=> status);
endmodule

// File: rtl/sdi_dma_irq.sv
module sdi_dma_irq
    import sdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCH-1:0]    wdata,
    output logic [NCH-1:0]    rdata,
    input  logic              tx_done,
    input  logic              rx_done,
    output logic              irq
);
    cfg_t           cfg;
    logic [NCH-1:0] clr_pulse;
    logic [NCH-1:0] done_vec;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] masked;

    always_comb begin
        done_vec        = '0;
        done_vec[CH_TX] = tx_done;
        done_vec[CH_RX] = rx_done;
    end

    sdi_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg       (cfg),
        .clr_pulse (clr_pulse)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            sdi_done_chan #(.SUSTAIN(ch_sustains(ch))) u_chan (
                .clk    (clk),
                .rst    (rst),
                .en     (cfg.dma_en[ch]),
                .done   (done_vec[ch]),
                .clr    (clr_pulse[ch]),
                .status (raw[ch])
            );
        end
    endgenerate

    assign masked = raw & cfg.mask;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |masked;
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:  rdata = cfg.dma_en;
            A_MASK:  rdata = cfg.mask;
            A_RAW:   rdata = raw;
            A_MSTAT: rdata = masked;
            default: rdata = '0;
        endcase
    end

    p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
        (|(raw & cfg.mask)) |=> irq);
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !(|(raw & cfg.mask)) |=> !irq);
endmodule

// File: tb/tb_sdi_dma_irq.sv
module tb_sdi_dma_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [1:0] wdata = '0;
    logic [1:0] rdata;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // reference state
    logic [1:0] m_en, m_mask, m_stat;
    logic       m_fin, m_irq;

    always #10 clk = ~clk;

    sdi_dma_irq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
    );

    function automatic logic [1:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd1: return m_mask;
            3'd2: return m_stat;
            3'd3: return m_stat & m_mask;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_mask = 0; m_stat = 0; m_fin = 0; m_irq = 0;
    endtask

    task automatic step(bit w, logic [2:0] a, logic [1:0] d, bit td, bit rd, string tag);
        logic [1:0] clr;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tx_done = td; rx_done = rd;
        #1;
        chk({tag, " rdata"}, rdata, m_read(a));
        chk({tag, " irq R9"}, {1'b0, irq}, {1'b0, m_irq});
        clr = (w && a == 3'd4) ? d : 2'b00;
        m_irq = |(m_stat & m_mask);
        m_stat[0] = (td & m_en[0]) | (m_fin & m_en[0]) | (m_stat[0] & ~clr[0]);
        m_stat[1] = (rd & m_en[1]) | (m_stat[1] & ~clr[1]);
        m_fin = m_en[0] ? (m_fin | td) : 1'b0;
        if (w && a == 3'd0) m_en = d;
        if (w && a == 3'd1) m_mask = d;
    endtask

    task automatic idle(string tag, logic [2:0] a);
        step(0, a, 2'b00, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done_flag) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 5; a++) idle("R1 reset", 3'(a));
        // R2 config read back
        step(1, 3'd0, 2'b11, 0, 0, "R2 ctrl write");
        idle("R2 ctrl read", 3'd0);
        step(1, 3'd1, 2'b11, 0, 0, "R2 mask write");
        idle("R2 mask read", 3'd1);
        // R3 rx one-shot, R9 irq
        step(0, 3'd2, 2'b00, 0, 1, "R3 rx done");
        idle("R3 raw set", 3'd2);
        idle("R3 raw held", 3'd2);
        // R5 clear rx, zero bits ignored
        step(1, 3'd4, 2'b00, 0, 0, "R5 clear zero");
        idle("R5 still set", 3'd2);
        step(1, 3'd4, 2'b10, 0, 0, "R5 clear rx");
        idle("R5 cleared", 3'd2);
        idle("R5 clr reads zero", 3'd4);
        // R6 tx sustain
        step(0, 3'd2, 2'b00, 1, 0, "R6 tx done");
        idle("R6 tx set", 3'd2);
        step(1, 3'd4, 2'b01, 0, 0, "R6 blocked clear");
        idle("R6 still set", 3'd2);
        idle("R6 still set 2", 3'd2);
        // R7 disable then clear, re-enable
        step(1, 3'd0, 2'b10, 0, 0, "R7 disable tx");
        step(1, 3'd4, 2'b01, 0, 0, "R7 clear tx");
        idle("R7 cleared", 3'd2);
        step(1, 3'd0, 2'b11, 0, 0, "R7 reenable");
        repeat (3) idle("R7 no reassert", 3'd2);
        step(0, 3'd2, 2'b00, 1, 0, "R7 new done");
        idle("R7 set again", 3'd2);
        step(1, 3'd0, 2'b10, 0, 0, "R7 disable");
        step(1, 3'd4, 2'b01, 0, 0, "R7 clear");
        // R4 done ignored when disabled
        step(1, 3'd0, 2'b00, 0, 0, "R4 disable all");
        step(0, 3'd2, 2'b00, 1, 1, "R4 done while off");
        idle("R4 raw stays 0", 3'd2);
        idle("R4 irq stays 0", 3'd3);
        // R10 same-cycle clear and event
        step(1, 3'd0, 2'b10, 0, 0, "R10 rx on");
        step(1, 3'd4, 2'b10, 0, 1, "R10 clear with done");
        idle("R10 raw still set", 3'd2);
        // R8 masked view
        step(1, 3'd0, 2'b11, 1, 0, "R8 tx on");
        step(0, 3'd2, 2'b00, 1, 0, "R8 tx done");
        step(1, 3'd1, 2'b01, 0, 0, "R8 mask tx only");
        idle("R8 masked", 3'd3);
        idle("R8 raw", 3'd2);
        step(1, 3'd1, 2'b00, 0, 0, "R8 mask none");
        idle("R8 masked none", 3'd3);
        idle("R8 irq low", 3'd2);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            bit w = (r < 5);
            logic [2:0] a = 3'($urandom_range(0, 5));
            if (r == 0) a = 3'd4;
            step(w, a, 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                 "R2 R3 R4 R5 R6 R7 R8 R10 random");
        end
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule